// File: doc/BRIEF.md
# Fractional Product Alignment Path

This block sits between a signed 16x16 multiplier and a 36-bit accumulator. It keeps a 32-bit product register. Each accepted operation carries two operands, an operation code, a shift mode and the present accumulator value. The block returns the new accumulator value and keeps the raw product visible. When the accumulator consumes the product, the stored product is first widened to 36 bits with its sign. It is then shifted by the selected mode, so that Q15 by Q15 results can land aligned in the high word. Accumulate and subtract use the product from the previous multiply. In the same step they capture the product of the new operands.

Operations arrive on a valid/ready channel and results leave on a second valid/ready channel. The result stage is a single register. An operation is taken when `op_valid` and `op_ready` are both high, and `op_ready` is high whenever the result register is empty or is being drained in the same cycle. A result is offered on `res_valid` one cycle after acceptance and stays unchanged until `res_ready` takes it. An offered result may be held back for any number of cycles. During that time no new operation is taken and the product register keeps its value.

Top module: `fpa_prod_align`

## Requirements
- R1: After reset the product register reads zero, `res_valid` is low and `op_ready` is high.
- R2: Operation code 0 (multiply) loads the signed product of `op_a` and `op_b` into the product register and returns `acc_in` unchanged as the result.
- R3: Operation code 1 (accumulate) returns `acc_in` plus the shifted previous product and loads the new signed product into the product register.
- R4: Operation code 2 (subtract) returns `acc_in` minus the shifted previous product and loads the new signed product into the product register.
- R5: Operation code 3 (round) returns the shifted product plus 0x8000 and leaves the product register unchanged.
- R6: Shift mode 0 passes the sign-extended 36-bit product unchanged, mode 1 shifts it right one bit with sign fill, mode 2 shifts it left one bit and mode 3 shifts it left two bits, both left shifts filling with zeros. The mode is taken with the operation.
- R7: With shift mode 2, a previous product of 0x4000 times 0x4000 (raw 0x10000000) gives an accumulated term whose bits 31:16 are 0x2000.
- R8: `res_ovf` is high only for accumulate or subtract results that leave the signed 36-bit range, and the result then wraps modulo 2^36. For multiply and round results it is always low.
- R9: `op_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, the result and flag hold and no operation is taken. The product register changes only on an accepted operation.
- R10: Shifting never alters the stored product: `prod_out` keeps the raw product after any shifted use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be taken this cycle |
| op_sel | input | 2 | 0 multiply, 1 accumulate, 2 subtract, 3 round |
| shift_mode | input | 2 | 0 none, 1 right 1, 2 left 1, 3 left 2 |
| op_a | input | 16 | First two's-complement operand |
| op_b | input | 16 | Second two's-complement operand |
| acc_in | input | 36 | Present accumulator value |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken this cycle |
| res_acc | output | 36 | New accumulator value |
| res_ovf | output | 1 | Signed 36-bit overflow of accumulate or subtract |
| prod_out | output | 32 | Raw product register |

## Verification
A wrong product register shows on `prod_out` at the first falling edge after the accepting clock edge. It shows in `res_acc` one operation later, when an accumulate, subtract or round consumes it. A faulty shift or sign fill appears only in the result of the operation that uses the product, so each mode is driven with a product whose sign makes the fill visible. A lost stall shows as a changed `res_acc` or `prod_out` while `res_ready` is held low.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic [1:0] {
    OP_MPY = 2'd0,
    OP_MAC = 2'd1,
    OP_MSU = 2'd2,
    OP_RND = 2'd3
  } fpa_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_R1   = 2'd1,
    SH_L1   = 2'd2,
    SH_L2   = 2'd3
  } fpa_shift_e;
endpackage

// File: rtl/fpa_shifter.sv
module fpa_shifter
  import fpa_pkg::*;
#(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 36
) (
  input  logic [PROD_W-1:0] prod_i,
  input  logic [1:0]        mode_i,
  output logic [ACC_W-1:0]  sh_o
);
  localparam int EXT_W = ACC_W - PROD_W;

  logic [ACC_W-1:0] ext;
  assign ext = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};

  always_comb begin
    case (fpa_shift_e'(mode_i))
      SH_NONE: sh_o = ext;
      SH_R1:   sh_o = {ext[ACC_W-1], ext[ACC_W-1:1]};
      SH_L1:   sh_o = {ext[ACC_W-2:0], 1'b0};
      SH_L2:   sh_o = {ext[ACC_W-3:0], 2'b00};
      default: sh_o = ext;
    endcase
  end
endmodule

// File: rtl/fpa_acc_unit.sv
module fpa_acc_unit
  import fpa_pkg::*;
#(
  parameter int ACC_W   = 36,
  parameter int RND_POS = 15
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] sh_i,
  input  fpa_op_e          op_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam logic [ACC_W-1:0] RND_K = ACC_W'(1) << RND_POS;

  logic [ACC_W-1:0] base, addend, sum;
  logic             cin;

  always_comb begin
    cin    = (op_i == OP_MSU);
    addend = cin ? ~sh_i : sh_i;
    base   = (op_i == OP_RND) ? RND_K : acc_i;
    sum    = base + addend + {{(ACC_W-1){1'b0}}, cin};
    case (op_i)
      OP_MAC, OP_MSU: begin
        acc_o = sum;
        ovf_o = (base[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != base[ACC_W-1]);
      end
      OP_RND: begin
        acc_o = sum;
        ovf_o = 1'b0;
      end
      default: begin
        acc_o = acc_i;
        ovf_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fpa_prod_align.sv
module fpa_prod_align
  import fpa_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [1:0]          op_sel,
  input  logic [1:0]          shift_mode,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  input  logic [ACC_W-1:0]    acc_in,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [ACC_W-1:0]    res_acc,
  output logic                res_ovf,
  output logic [2*OP_W-1:0]   prod_out
);
  localparam int PROD_W = 2 * OP_W;

  fpa_op_e                  opc;
  logic                     fire;
  logic signed [PROD_W-1:0] mult;
  logic [PROD_W-1:0]        prod_q;
  logic [ACC_W-1:0]         shifted, acc_next;
  logic                     ovf_next;

  assign opc      = fpa_op_e'(op_sel);
  assign op_ready = !res_valid || res_ready;
  assign fire     = op_valid && op_ready;
  assign mult     = $signed(op_a) * $signed(op_b);
  assign prod_out = prod_q;

  fpa_shifter #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_shift (
    .prod_i (prod_q),
    .mode_i (shift_mode),
    .sh_o   (shifted)
  );

  fpa_acc_unit #(.ACC_W(ACC_W), .RND_POS(OP_W-1)) u_acc (
    .acc_i (acc_in),
    .sh_i  (shifted),
    .op_i  (opc),
    .acc_o (acc_next),
    .ovf_o (ovf_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q    <= '0;
      res_valid <= 1'b0;
      res_acc   <= '0;
      res_ovf   <= 1'b0;
    end else begin
      if (fire && opc != OP_RND) prod_q <= mult;
      if (fire) begin
        res_valid <= 1'b1;
        res_acc   <= acc_next;
        res_ovf   <= ovf_next;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R9 handshake and hold rules
  a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> op_ready);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_acc) && $stable(res_ovf)));
  a_r9_idle_prod: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(prod_out));
  // R5 round keeps the product register
  a_r5_rnd_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && opc == OP_RND) |=> $stable(prod_out));
  // R2 multiply passes the accumulator through
  a_r2_mpy_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && opc == OP_MPY) |=> (res_acc == $past(acc_in)));
  // R8 flag only from accumulate or subtract
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (opc == OP_MPY || opc == OP_RND)) |=> !res_ovf);
endmodule

// File: tb/fpa_prod_align_test.sv
`timescale 1ns/1ps
module fpa_prod_align_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_sel = 2'd0;
  logic [1:0]  shift_mode = 2'd0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [35:0] acc_in = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [35:0] res_acc;
  logic        res_ovf;
  logic [31:0] prod_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_prod = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpa_prod_align uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .shift_mode(shift_mode), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .res_valid(res_valid), .res_ready(res_ready),
    .res_acc(res_acc), .res_ovf(res_ovf), .prod_out(prod_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [35:0] shift_ref(input logic [31:0] p, input logic [1:0] m);
    logic signed [35:0] e;
    e = {{4{p[31]}}, p};
    case (m)
      2'd0: return e;
      2'd1: return e >>> 1;
      2'd2: return e << 1;
      default: return e << 2;
    endcase
  endfunction

  function automatic logic [31:0] mul_ref(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  // Called at a falling edge; issues one operation and checks its result.
  task automatic do_op(input string req, input logic [1:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [1:0] mode, input logic [35:0] acc);
    logic [35:0] sh, e_acc;
    logic        e_ovf;
    logic signed [36:0] w;
    sh = shift_ref(m_prod, mode);
    e_ovf = 1'b0;
    case (op)
      2'd0: e_acc = acc;
      2'd1: begin w = {acc[35], acc} + {sh[35], sh}; e_acc = w[35:0]; e_ovf = w[36] != w[35]; end
      2'd2: begin w = {acc[35], acc} - {sh[35], sh}; e_acc = w[35:0]; e_ovf = w[36] != w[35]; end
      default: e_acc = sh + 36'h8000;
    endcase
    if (op != 2'd3) m_prod = mul_ref(a, b);
    op_valid = 1'b1; op_sel = op; op_a = a; op_b = b; shift_mode = mode; acc_in = acc;
    res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, "res_valid", {35'd0, res_valid}, 36'd1);
    chk(req, "res_acc", res_acc, e_acc);
    chk("R8", "res_ovf", {35'd0, res_ovf}, {35'd0, e_ovf});
    chk(req, "prod_out", {4'd0, prod_out}, {4'd0, m_prod});
  endtask

  task automatic t_reset;
    chk("R1", "prod_out", {4'd0, prod_out}, 36'd0);
    chk("R1", "res_valid", {35'd0, res_valid}, 36'd0);
    chk("R1", "op_ready", {35'd0, op_ready}, 36'd1);
  endtask

  task automatic t_mpy;  // R2 most negative operands
    do_op("R2", 2'd0, 16'h8000, 16'h8000, 2'd2, 36'h123456789);
    chk("R2", "raw product", {4'd0, prod_out}, 36'h040000000);
  endtask

  task automatic t_mac_none;  // R3 with shift mode 0 (R6)
    do_op("R3", 2'd1, 16'hFFFF, 16'h0003, 2'd0, 36'd100);
  endtask

  task automatic t_msu_right;  // R4, R6 right shift of a negative product keeps sign
    do_op("R4", 2'd2, 16'h4000, 16'h4000, 2'd1, 36'd10);
    chk("R6", "sign fill", res_acc, 36'd12);
  endtask

  task automatic t_q15;  // R7
    do_op("R7", 2'd1, 16'h7FFF, 16'h7FFF, 2'd2, 36'd0);
    chk("R7", "high word", {20'd0, res_acc[31:16]}, 36'h2000);
  endtask

  task automatic t_round;  // R5, R10, R6 two-bit left
    do_op("R5", 2'd3, 16'h1111, 16'h2222, 2'd3, 36'hABCDE);
    chk("R10", "raw kept", {4'd0, prod_out}, 36'h03FFF0001);
    chk("R6", "left two", res_acc, 36'h0FFFC8004);
  endtask

  task automatic t_overflow;  // R8
    do_op("R8", 2'd1, 16'h8000, 16'h7FFF, 2'd0, 36'h7FFFFFFFF);
    chk("R8", "ovf set", {35'd0, res_ovf}, 36'd1);
    do_op("R8", 2'd2, 16'h0001, 16'h0001, 2'd0, 36'h800000000);
    chk("R8", "ovf clear", {35'd0, res_ovf}, 36'd0);
    do_op("R8", 2'd2, 16'h0002, 16'h0003, 2'd0, 36'h800000000);
    chk("R8", "wrap", res_acc, 36'h7FFFFFFFF);
  endtask

  task automatic t_stall;  // R9
    logic [35:0] held;
    @(negedge clk);
    res_ready = 1'b0;
    op_valid = 1'b1; op_sel = 2'd0; op_a = 16'h0010; op_b = 16'h0020;
    shift_mode = 2'd0; acc_in = 36'h55;
    m_prod = mul_ref(16'h0010, 16'h0020);
    @(negedge clk);
    chk("R9", "first taken", {35'd0, res_valid}, 36'd1);
    held = res_acc;
    op_sel = 2'd1; op_a = 16'h0100; op_b = 16'h0100; acc_in = 36'h1000;
    chk("R9", "ready low", {35'd0, op_ready}, 36'd0);
    repeat (3) @(negedge clk);
    chk("R9", "result held", res_acc, held);
    chk("R9", "product held", {4'd0, prod_out}, {4'd0, m_prod});
    res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9", "second result", res_acc, 36'h1000 + 36'h200);
    m_prod = mul_ref(16'h0100, 16'h0100);
    chk("R9", "second product", {4'd0, prod_out}, {4'd0, m_prod});
    @(negedge clk);
    chk("R9", "drained", {35'd0, res_valid}, 36'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mpy();
    t_mac_none();
    t_msu_right();
    t_q15();
    t_round();
    t_overflow();
    t_stall();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule